// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and border indication for a raster video output, together with the outgoing pixel value. A single position counter runs over every pixel clock of the frame, and a second counter tracks the position within the current line. Horizontal events are set as offsets within the line. Vertical events are set as absolute pixel-clock offsets from the start of the frame, so a vertical edge can fall part-way through a line. A programmable skew applied to those offsets moves the display window relative to the horizontal grid.

Inside the display window, an optional inner active window can be enabled separately in each direction. Pixels that are in the display window but outside an enabled active window carry a fixed border colour. Pixels inside the active region pass the input pixel through, or carry a fixed underflow colour in any clock where the pixel source flags underflow. In wide-bus mode, a data-valid output covers only the first half of each display line. A frame counter and a line counter are brought out for observation.

Every configuration input is captured into a shadow copy. The copy follows the inputs freely while the engine is off, and updates only at the frame boundary while it runs.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset with the engine off, hsync, vsync, de, border and data_valid are 0, pix_out is 0, and frame_cnt and line_cnt are 0.
- R2: With the engine on, the line length is hctl[31:16] clocks. Raw hsync is active for line positions 0 to hctl[15:0]-1.
- R3: The frame length is vs_period clocks. Raw vsync is active for frame positions 0 to vs_pulse-1.
- R4: Raw de is active when the frame position lies in [dv_start, dv_end] and the line position lies in [disp_hctl[15:0], disp_hctl[31:16]].
- R5: Each of polarity bit 0 (hsync), bit 1 (vsync) and bit 2 (de) inverts its output when set. With the engine off, each output sits at its polarity bit.
- R6: When act_h_en is set, columns outside [act_hctl[15:0], act_hctl[31:16]] are border. When act_v_en is set, frame positions outside [av_start, av_end] are border. The border output is 1 only inside raw de. A border pixel carries border_color.
- R7: pix_out is 0 outside raw de. Inside raw de and outside the border, it is underflow_color when pix_underflow is 1, and pix_in otherwise.
- R8: data_valid is raw de limited to line positions up to the data end. The data end is disp_hctl[31:16] normally. With wide_bus set, it is start + (end−start+1)/2 − 1.
- R9: frame_cnt increases by one at each frame wrap. line_cnt increases at each line wrap and returns to 0 at each frame wrap.
- R10: A configuration change made while the engine runs has no effect until the frame position wraps to 0.
- R11: One clock after the engine is switched off, the position, frame_cnt and line_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_en | input | 1 | Timing engine run enable |
| hctl | input | 2*HW | Line period [31:16], hsync pulse width [15:0] |
| vs_period | input | FW | Frame length in clocks |
| vs_pulse | input | FW | Vsync pulse length in clocks |
| dv_start | input | FW | First frame position of the display window |
| dv_end | input | FW | Last frame position of the display window |
| disp_hctl | input | 2*HW | Display column end [31:16], start [15:0] |
| act_hctl | input | 2*HW | Active column end [31:16], start [15:0] |
| av_start | input | FW | First frame position of the active window |
| av_end | input | FW | Last frame position of the active window |
| act_h_en | input | 1 | Apply horizontal active window |
| act_v_en | input | 1 | Apply vertical active window |
| polarity | input | 3 | Inversion bits: de, vsync, hsync |
| wide_bus | input | 1 | Half-width data window |
| border_color | input | PW | Border fill pixel |
| underflow_color | input | PW | Underflow fill pixel |
| pix_in | input | PW | Incoming pixel |
| pix_underflow | input | 1 | Pixel source underflow flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| border | output | 1 | Border region indication |
| data_valid | output | 1 | Data window indication |
| pix_out | output | PW | Outgoing pixel |
| frame_cnt | output | FCW | Frames since enable |
| line_cnt | output | HW | Line within current frame |

## Verification
On every clock, the embedded properties hold the position counters below their programmed periods, check the frame-wrap step of the counters and their clearing when the engine is off, confirm that the shadow copy stays unchanged between load points, and tie the idle sync levels and blanked pixel to the polarity and window state. Only the bench's frame sweeps can show the exact placement of the sync pulses, the display, active and wide-bus data windows, including a skewed vertical window that starts mid-line, and the colour selection. The same sweeps show that a mid-frame configuration change stays invisible until the next frame.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
   typedef enum logic [1:0] {
      PSRC_BLANK,
      PSRC_BORDER,
      PSRC_UNDERFLOW,
      PSRC_LIVE
   } pix_src_e;

   localparam int POL_HSYNC = 0;
   localparam int POL_VSYNC = 1;
   localparam int POL_DE    = 2;
endpackage

// File: rtl/rvt_shadow.sv
module rvt_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R10
endmodule

// File: rtl/rvt_frame_counter.sv
module rvt_frame_counter #(
   parameter int HW  = 16,
   parameter int FW  = 24,
   parameter int FCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic [HW-1:0]  h_period,
   input  logic [FW-1:0]  v_period,
   output logic [FW-1:0]  pos,
   output logic [HW-1:0]  hpos,
   output logic [HW-1:0]  line_cnt,
   output logic [FCW-1:0] frame_cnt,
   output logic           frame_wrap
);
   logic h_wrap;
   assign h_wrap     = (hpos == h_period - HW'(1));
   assign frame_wrap = en && (pos == v_period - FW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0; hpos <= '0; line_cnt <= '0; frame_cnt <= '0;
      end else if (!en) begin
         pos <= '0; hpos <= '0; line_cnt <= '0; frame_cnt <= '0;
      end else if (frame_wrap) begin
         pos       <= '0;
         hpos      <= '0;
         line_cnt  <= '0;
         frame_cnt <= frame_cnt + FCW'(1);
      end else begin
         pos <= pos + FW'(1);
         if (h_wrap) begin
            hpos     <= '0;
            line_cnt <= line_cnt + HW'(1);
         end else begin
            hpos <= hpos + HW'(1);
         end
      end
   end

   AST_HPOS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (en && h_period != '0) |-> (hpos < h_period)); // R2
   AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_period != '0) |-> (pos < v_period)); // R3
   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wrap |=> (frame_cnt == $past(frame_cnt) + FCW'(1) && line_cnt == '0 && pos == '0)); // R9
   AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (frame_cnt == '0 && line_cnt == '0 && pos == '0)); // R11
endmodule

// File: rtl/rvt_pixel_path.sv
module rvt_pixel_path
   import rvt_pkg::*;
#(
   parameter int HW          = 16,
   parameter int FW          = 24,
   parameter int PW          = 24,
   parameter bit WIDE_BUS_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [FW-1:0] pos,
   input  logic [HW-1:0] hpos,
   input  logic [HW-1:0] h_pulse,
   input  logic [FW-1:0] vs_pulse,
   input  logic [FW-1:0] dv_start,
   input  logic [FW-1:0] dv_end,
   input  logic [HW-1:0] h_start,
   input  logic [HW-1:0] h_end,
   input  logic [HW-1:0] ah_start,
   input  logic [HW-1:0] ah_end,
   input  logic [FW-1:0] av_start,
   input  logic [FW-1:0] av_end,
   input  logic          act_h_en,
   input  logic          act_v_en,
   input  logic [2:0]    polarity,
   input  logic          wide_bus,
   input  logic [PW-1:0] border_color,
   input  logic [PW-1:0] underflow_color,
   input  logic [PW-1:0] pix_in,
   input  logic          pix_underflow,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          border_o,
   output logic          dv_o,
   output logic [PW-1:0] pix_o
);
   logic          hs_raw, vs_raw, de_raw, in_act;
   logic [HW-1:0] data_end;
   pix_src_e      src;

   generate
      if (WIDE_BUS_EN) begin : g_wide
         logic [HW:0] span;
         assign span     = {1'b0, h_end} - {1'b0, h_start} + (HW+1)'(1);
         assign data_end = wide_bus ? (h_start + HW'(span >> 1) - HW'(1)) : h_end;
      end else begin : g_narrow
         assign data_end = h_end;
      end
   endgenerate

   assign hs_raw = en && (hpos < h_pulse);
   assign vs_raw = en && (pos < vs_pulse);
   assign de_raw = en && (pos >= dv_start) && (pos <= dv_end)
                      && (hpos >= h_start) && (hpos <= h_end);
   assign in_act = (!act_h_en || (hpos >= ah_start && hpos <= ah_end))
                && (!act_v_en || (pos >= av_start && pos <= av_end));

   always_comb begin
      if (!de_raw)           src = PSRC_BLANK;
      else if (!in_act)      src = PSRC_BORDER;
      else if (pix_underflow) src = PSRC_UNDERFLOW;
      else                   src = PSRC_LIVE;
   end

   always_comb begin
      case (src)
         PSRC_BORDER:    pix_o = border_color;
         PSRC_UNDERFLOW: pix_o = underflow_color;
         PSRC_LIVE:      pix_o = pix_in;
         default:        pix_o = '0;
      endcase
   end

   assign border_o = de_raw && !in_act;
   assign dv_o     = de_raw && (hpos <= data_end);
   assign hsync_o  = hs_raw ^ polarity[POL_HSYNC];
   assign vsync_o  = vs_raw ^ polarity[POL_VSYNC];
   assign de_o     = de_raw ^ polarity[POL_DE];

   AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (hsync_o == polarity[POL_HSYNC] && vsync_o == polarity[POL_VSYNC]
               && de_o == polarity[POL_DE])); // R5
   AST_PIX_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (de_o == polarity[POL_DE]) |-> (pix_o == '0 && !border_o && !dv_o)); // R7
   AST_UNDERFLOW_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (de_o != polarity[POL_DE] && !border_o && pix_underflow) |-> (pix_o == underflow_color)); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
   parameter int HW          = 16,
   parameter int FW          = 24,
   parameter int PW          = 24,
   parameter int FCW         = 16,
   parameter bit WIDE_BUS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            eng_en,
   input  logic [2*HW-1:0] hctl,
   input  logic [FW-1:0]   vs_period,
   input  logic [FW-1:0]   vs_pulse,
   input  logic [FW-1:0]   dv_start,
   input  logic [FW-1:0]   dv_end,
   input  logic [2*HW-1:0] disp_hctl,
   input  logic [2*HW-1:0] act_hctl,
   input  logic [FW-1:0]   av_start,
   input  logic [FW-1:0]   av_end,
   input  logic            act_h_en,
   input  logic            act_v_en,
   input  logic [2:0]      polarity,
   input  logic            wide_bus,
   input  logic [PW-1:0]   border_color,
   input  logic [PW-1:0]   underflow_color,
   input  logic [PW-1:0]   pix_in,
   input  logic            pix_underflow,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic            border,
   output logic            data_valid,
   output logic [PW-1:0]   pix_out,
   output logic [FCW-1:0]  frame_cnt,
   output logic [HW-1:0]   line_cnt
);
   localparam int SW = 6*HW + 6*FW + 6 + 2*PW;

   initial begin
      assert (HW >= 4 && FW >= HW && PW >= 1 && FCW >= 1)
         else $error("raster_timing_gen: invalid width parameters");
   end

   logic [SW-1:0]   cfg_bus, shd_bus;
   logic [2*HW-1:0] s_hctl, s_disp, s_act;
   logic [FW-1:0]   s_vsp, s_vspl, s_dvs, s_dve, s_avs, s_ave;
   logic            s_ahen, s_aven, s_wide;
   logic [2:0]      s_pol;
   logic [PW-1:0]   s_bcol, s_ucol;
   logic [FW-1:0]   pos;
   logic [HW-1:0]   hpos;
   logic            frame_wrap;

   assign cfg_bus = {hctl, disp_hctl, act_hctl, vs_period, vs_pulse, dv_start, dv_end,
                     av_start, av_end, act_h_en, act_v_en, polarity, wide_bus,
                     border_color, underflow_color};
   assign {s_hctl, s_disp, s_act, s_vsp, s_vspl, s_dvs, s_dve, s_avs, s_ave,
           s_ahen, s_aven, s_pol, s_wide, s_bcol, s_ucol} = shd_bus;

   rvt_shadow #(.W(SW)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(!eng_en || frame_wrap), .d(cfg_bus), .q(shd_bus)
   );

   rvt_frame_counter #(.HW(HW), .FW(FW), .FCW(FCW)) u_count (
      .clk(clk), .rst_n(rst_n), .en(eng_en),
      .h_period(s_hctl[2*HW-1:HW]), .v_period(s_vsp),
      .pos(pos), .hpos(hpos), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
      .frame_wrap(frame_wrap)
   );

   rvt_pixel_path #(.HW(HW), .FW(FW), .PW(PW), .WIDE_BUS_EN(WIDE_BUS_EN)) u_pix (
      .clk(clk), .rst_n(rst_n), .en(eng_en), .pos(pos), .hpos(hpos),
      .h_pulse(s_hctl[HW-1:0]), .vs_pulse(s_vspl),
      .dv_start(s_dvs), .dv_end(s_dve),
      .h_start(s_disp[HW-1:0]), .h_end(s_disp[2*HW-1:HW]),
      .ah_start(s_act[HW-1:0]), .ah_end(s_act[2*HW-1:HW]),
      .av_start(s_avs), .av_end(s_ave),
      .act_h_en(s_ahen), .act_v_en(s_aven), .polarity(s_pol), .wide_bus(s_wide),
      .border_color(s_bcol), .underflow_color(s_ucol),
      .pix_in(pix_in), .pix_underflow(pix_underflow),
      .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .border_o(border),
      .dv_o(data_valid), .pix_o(pix_out)
   );
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
   localparam int HW = 16, FW = 24, PW = 24, FCW = 16;

   logic clk = 1'b0, rst_n = 1'b0, eng_en = 1'b0;
   logic [2*HW-1:0] hctl = '0, disp_hctl = '0, act_hctl = '0;
   logic [FW-1:0]   vs_period = '0, vs_pulse = '0, dv_start = '0, dv_end = '0;
   logic [FW-1:0]   av_start = '0, av_end = '0;
   logic            act_h_en = 1'b0, act_v_en = 1'b0, wide_bus = 1'b0, pix_underflow = 1'b0;
   logic [2:0]      polarity = '0;
   logic [PW-1:0]   border_color = '0, underflow_color = '0, pix_in = '0;
   logic            hsync, vsync, de, border, data_valid;
   logic [PW-1:0]   pix_out;
   logic [FCW-1:0]  frame_cnt;
   logic [HW-1:0]   line_cnt;

   always #5 clk = ~clk;

   raster_timing_gen u_raster_timing_gen (
      .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .hctl(hctl), .vs_period(vs_period),
      .vs_pulse(vs_pulse), .dv_start(dv_start), .dv_end(dv_end), .disp_hctl(disp_hctl),
      .act_hctl(act_hctl), .av_start(av_start), .av_end(av_end), .act_h_en(act_h_en),
      .act_v_en(act_v_en), .polarity(polarity), .wide_bus(wide_bus),
      .border_color(border_color), .underflow_color(underflow_color), .pix_in(pix_in),
      .pix_underflow(pix_underflow), .hsync(hsync), .vsync(vsync), .de(de),
      .border(border), .data_valid(data_valid), .pix_out(pix_out),
      .frame_cnt(frame_cnt), .line_cnt(line_cnt)
   );

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   // bench view of the shadowed configuration and of the position
   int m_pos = 0, m_frame = 0;
   int s_hp = 0, s_hpl = 0, s_hs = 0, s_he = 0, s_ahs = 0, s_ahe = 0;
   int s_vsp = 0, s_vspl = 0, s_dvs = 0, s_dve = 0, s_avs = 0, s_ave = 0;
   bit s_ahen = 0, s_aven = 0, s_wide = 0;
   bit [2:0] s_pol = '0;
   int s_bcol = 0, s_ucol = 0;
   bit nx_en = 0, pend_b = 0;
   string tg_hs = "R2", tg_de = "R4", tg_cnt = "R9", phase = "reset";

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s [%s] pos=%0d act=%0h exp=%0h", req, what, phase, m_pos, act, exp);
      end
   endtask

   task automatic set_cfg_a();
      hctl = {16'd10, 16'd2}; disp_hctl = {16'd8, 16'd4}; act_hctl = {16'd7, 16'd5};
      vs_period = 60; vs_pulse = 10; dv_start = 20; dv_end = 49;
      av_start = 30; av_end = 39; act_h_en = 0; act_v_en = 0;
      polarity = 3'b000; wide_bus = 0;
      border_color = 24'hB0B0B0; underflow_color = 24'hFF0000;
   endtask

   task automatic set_cfg_b();
      hctl = {16'd10, 16'd3}; dv_start = 23; dv_end = 52;
      act_h_en = 1; act_v_en = 1; polarity = 3'b101; wide_bus = 1;
      border_color = 24'h00AA55; underflow_color = 24'h123456;
   endtask

   task automatic cycle();
      int h, dend, e_pix;
      bit e_hs, e_vs, e_de, e_ok, e_bd, e_dv, wrap;
      @(negedge clk);
      if (pend_b) begin set_cfg_b(); pend_b = 0; end
      eng_en = nx_en;
      pix_in = 24'(m_pos * 37 + 5);
      pix_underflow = (m_pos % 7 == 3);
      #1;
      h    = (s_hp != 0) ? m_pos % s_hp : 0;
      e_hs = eng_en && h < s_hpl;
      e_vs = eng_en && m_pos < s_vspl;
      e_de = eng_en && m_pos >= s_dvs && m_pos <= s_dve && h >= s_hs && h <= s_he;
      e_ok = (!s_ahen || (h >= s_ahs && h <= s_ahe)) && (!s_aven || (m_pos >= s_avs && m_pos <= s_ave));
      e_bd = e_de && !e_ok;
      dend = s_wide ? s_hs + (s_he - s_hs + 1) / 2 - 1 : s_he;
      e_dv = e_de && h <= dend;
      e_pix = !e_de ? 0 : e_bd ? s_bcol : pix_underflow ? s_ucol : int'(pix_in);
      chk(tg_hs, "hsync", 32'(hsync), 32'(e_hs ^ s_pol[0]));
      chk("R3", "vsync", 32'(vsync), 32'(e_vs ^ s_pol[1]));
      chk(tg_de, "de", 32'(de), 32'(e_de ^ s_pol[2]));
      chk("R6", "border", 32'(border), 32'(e_bd));
      chk("R8", "data_valid", 32'(data_valid), 32'(e_dv));
      chk("R7", "pix_out", 32'(pix_out), 32'(e_pix));
      chk(tg_cnt, "line_cnt", 32'(line_cnt), 32'((s_hp != 0) ? m_pos / s_hp : 0));
      chk(tg_cnt, "frame_cnt", 32'(frame_cnt), 32'(m_frame));
      // next state, as seen at the coming rising edge
      wrap = eng_en && (m_pos == s_vsp - 1);
      if (!eng_en)   begin m_pos = 0; m_frame = 0; end
      else if (wrap) begin m_pos = 0; m_frame++; end
      else           m_pos++;
      if (!eng_en || wrap) begin
         s_hp = int'(hctl[31:16]); s_hpl = int'(hctl[15:0]);
         s_hs = int'(disp_hctl[15:0]); s_he = int'(disp_hctl[31:16]);
         s_ahs = int'(act_hctl[15:0]); s_ahe = int'(act_hctl[31:16]);
         s_vsp = int'(vs_period); s_vspl = int'(vs_pulse);
         s_dvs = int'(dv_start); s_dve = int'(dv_end);
         s_avs = int'(av_start); s_ave = int'(av_end);
         s_ahen = act_h_en; s_aven = act_v_en; s_wide = wide_bus; s_pol = polarity;
         s_bcol = int'(border_color); s_ucol = int'(underflow_color);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state, engine off
      phase = "R1 reset"; tg_hs = "R1"; tg_de = "R1"; tg_cnt = "R1";
      cycle();
      set_cfg_a();
      cycle();
      // R2 R3 R4 R7 R9: plain frames, no windows, no inversion
      phase = "config A"; tg_hs = "R2"; tg_de = "R4"; tg_cnt = "R9";
      nx_en = 1;
      for (int i = 0; i < 90; i++) cycle();
      // R10: new values written mid-frame must not show before the wrap
      phase = "R10 pending"; tg_hs = "R10"; tg_de = "R10";
      pend_b = 1;
      for (int i = 0; i < 30; i++) cycle();
      // R5 R6 R8: skewed window, active windows, inversion, wide bus
      phase = "config B"; tg_hs = "R5"; tg_de = "R5";
      for (int i = 0; i < 120; i++) cycle();
      // R11: switch the engine off
      phase = "R11 off"; tg_cnt = "R11";
      nx_en = 0;
      for (int i = 0; i < 3; i++) cycle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule